// File: doc/BRIEF.md
# Filtered Branch History Stack

This block keeps a short history of the most recent taken control transfers. Each history entry is a pair of addresses: where the branch came from and where it went. The entries sit in a small ring of registers. When every slot is in use, a new branch overwrites the oldest one. Two filter inputs can stop conditional branches or near returns from being captured, so that software sees only the transfers it cares about.

A combinational read port takes an index counted back from the newest entry and returns the stored pair together with its valid flag. A top-of-stack pointer output shows which slot holds the newest entry. Reading never changes what is recorded.

Capture can be paused with `freeze`, and the contents survive the pause. A separate `wipe` input invalidates every entry. The number of entries and the address width are parameters.

Top module: `branch_hist_stack`

## Requirements
- R1: After reset, `tos` is 0 and `rd_vld` is 0 for every read index.
- R2: An accepted branch is written into slot (`tos`+1) modulo DEPTH, and `tos` moves to that slot at the same clock edge.
- R3: With `skip_cond` high, a branch of kind 0 (conditional) is not captured and `tos` does not move.
- R4: With `skip_ret` high, a branch of kind 3 (near return) is not captured and `tos` does not move.
- R5: The following kinds are captured unless a filter blocks them: 0 conditional, 1 jump, 2 call, 3 near return, 4 interrupt and 5 exception. Kinds 6 and 7 are never captured.
- R6: Read index k returns the k-th newest pair, with index 0 being the newest, and raises `rd_vld` for it. An invalid entry reads as zero with `rd_vld` low. After DEPTH+1 captures, the first one is no longer present.
- R7: While `freeze` is high, no branch is captured, and `tos` and the stored pairs stay unchanged.
- R8: `wipe` clears every valid flag at the next edge and leaves `tos` as it was. It takes precedence over a capture in the same cycle, and that branch is dropped.
- R9: A read in the same cycle as a capture returns the contents from before that capture, even when it addresses the slot being overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| br_valid | input | 1 | A retired branch is presented this cycle |
| br_kind | input | 3 | Branch kind code (see R5) |
| br_src | input | AW | Branch source address |
| br_dst | input | AW | Branch target address |
| skip_cond | input | 1 | Drop conditional branches |
| skip_ret | input | 1 | Drop near returns |
| freeze | input | 1 | Pause capture and keep the contents |
| wipe | input | 1 | Invalidate all entries |
| rd_idx | input | IDXW | Read index counted back from the newest entry |
| rd_vld | output | 1 | The addressed entry holds a record |
| rd_src | output | AW | Stored source address |
| rd_dst | output | AW | Stored target address |
| tos | output | IDXW | Slot of the newest entry |

## Verification
A capture and a read can happen in the same cycle. The bench provokes this by presenting an accepted branch while the read index points at the oldest entry, which is exactly the slot that branch will overwrite. Before the edge it expects the old pair on the read port. After the edge it expects the new pair at index 0 and the next-older pair at the last index.

A capture and a wipe can also coincide. The bench raises both together and expects `tos` to stay where it was and every entry to read as invalid.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [2:0] {
    BK_COND = 3'd0,
    BK_JMP  = 3'd1,
    BK_CALL = 3'd2,
    BK_RET  = 3'd3,
    BK_IRQ  = 3'd4,
    BK_EXC  = 3'd5,
    BK_RSV6 = 3'd6,
    BK_RSV7 = 3'd7
  } br_kind_e;
endpackage

// File: rtl/bh_filter.sv
module bh_filter
  import bh_pkg::*;
(
  input  logic       br_valid,
  input  logic [2:0] br_kind,
  input  logic       skip_cond,
  input  logic       skip_ret,
  input  logic       freeze,
  output logic       take
);
  logic kind_ok;

  always_comb begin
    case (br_kind_e'(br_kind))
      BK_COND: kind_ok = !skip_cond;
      BK_RET:  kind_ok = !skip_ret;
      BK_JMP, BK_CALL, BK_IRQ, BK_EXC: kind_ok = 1'b1;
      default: kind_ok = 1'b0;
    endcase
    take = br_valid && !freeze && kind_ok;
  end
endmodule

// File: rtl/bh_ptr.sv
module bh_ptr #(
  parameter int DEPTH = 4,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [IDXW-1:0] tos,
  output logic [IDXW-1:0] wr_slot
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);
  logic [IDXW-1:0] tos_q, tos_nxt;

  always_comb begin
    wr_slot = (tos_q == LAST) ? '0 : tos_q + 1'b1;
    tos_nxt = adv ? wr_slot : tos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos_q <= '0;
    else        tos_q <= tos_nxt;
  end

  assign tos = tos_q;
endmodule

// File: rtl/bh_entry.sv
module bh_entry #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          clr,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  output logic          vld,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst
);
  logic vld_q, vld_nxt;
  logic [AW-1:0] src_q, dst_q;

  always_comb begin
    if (clr)        vld_nxt = 1'b0;
    else if (wr_en) vld_nxt = 1'b1;
    else            vld_nxt = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_nxt;
  end

  // Address payload carries no reset; the valid flag qualifies it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_q <= src_in;
      dst_q <= dst_in;
    end
  end

  assign vld = vld_q;
  assign src = src_q;
  assign dst = dst_q;
endmodule

// File: rtl/bh_rdmux.sv
module bh_rdmux #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IDXW-1:0]           tos,
  input  logic [IDXW-1:0]           rd_idx,
  input  logic [DEPTH-1:0]          ent_vld,
  input  logic [DEPTH-1:0][AW-1:0]  ent_src,
  input  logic [DEPTH-1:0][AW-1:0]  ent_dst,
  output logic                      rd_vld,
  output logic [AW-1:0]             rd_src,
  output logic [AW-1:0]             rd_dst
);
  localparam logic [IDXW:0] DEP_W = (IDXW+1)'(DEPTH);
  logic [IDXW:0]   sum;
  logic [IDXW-1:0] sel;
  logic            idx_ok;

  always_comb begin
    // slot = (tos - rd_idx) mod DEPTH, kept non-negative by adding DEPTH
    sum    = {1'b0, tos} + DEP_W - {1'b0, rd_idx};
    if (sum >= DEP_W) sum = sum - DEP_W;
    sel    = sum[IDXW-1:0];
    idx_ok = ({1'b0, rd_idx} < DEP_W);
    rd_vld = idx_ok && ent_vld[sel];
    rd_src = rd_vld ? ent_src[sel] : '0;
    rd_dst = rd_vld ? ent_dst[sel] : '0;
  end
endmodule

// File: rtl/branch_hist_stack.sv
module branch_hist_stack
  import bh_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [2:0]      br_kind,
  input  logic [AW-1:0]   br_src,
  input  logic [AW-1:0]   br_dst,
  input  logic            skip_cond,
  input  logic            skip_ret,
  input  logic            freeze,
  input  logic            wipe,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_vld,
  output logic [AW-1:0]   rd_src,
  output logic [AW-1:0]   rd_dst,
  output logic [IDXW-1:0] tos
);
  logic                     take;
  logic                     adv;
  logic [IDXW-1:0]          wr_slot;
  logic [DEPTH-1:0]         ent_vld;
  logic [DEPTH-1:0][AW-1:0] ent_src;
  logic [DEPTH-1:0][AW-1:0] ent_dst;

  bh_filter u_filter (
    .br_valid (br_valid),
    .br_kind  (br_kind),
    .skip_cond(skip_cond),
    .skip_ret (skip_ret),
    .freeze   (freeze),
    .take     (take)
  );

  assign adv = take && !wipe;

  bh_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .tos    (tos),
    .wr_slot(wr_slot)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = adv && (wr_slot == IDXW'(g));
    bh_entry #(.AW(AW)) u_entry (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (hit),
      .clr   (wipe),
      .src_in(br_src),
      .dst_in(br_dst),
      .vld   (ent_vld[g]),
      .src   (ent_src[g]),
      .dst   (ent_dst[g])
    );
  end

  bh_rdmux #(.DEPTH(DEPTH), .AW(AW)) u_rdmux (
    .tos    (tos),
    .rd_idx (rd_idx),
    .ent_vld(ent_vld),
    .ent_src(ent_src),
    .ent_dst(ent_dst),
    .rd_vld (rd_vld),
    .rd_src (rd_src),
    .rd_dst (rd_dst)
  );
endmodule

// File: rtl/bh_chk.sv
module bh_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic [2:0]      br_kind,
  input logic [AW-1:0]   br_src,
  input logic            skip_cond,
  input logic            skip_ret,
  input logic            freeze,
  input logic            wipe,
  input logic [IDXW-1:0] rd_idx,
  input logic            rd_vld,
  input logic [AW-1:0]   rd_src,
  input logic [IDXW-1:0] tos,
  input logic            take,
  input logic [DEPTH-1:0] ent_vld
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wipe) |=> (tos == (($past(tos) == LAST) ? '0 : $past(tos) + 1'b1)));

  p_cond_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd0 && skip_cond) |=> $stable(tos));

  p_ret_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd3 && skip_ret) |=> $stable(tos));

  p_rsv_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind[2:1] == 2'b11) |=> $stable(tos));

  p_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wipe) |=> (rd_idx != '0 || (rd_vld && rd_src == $past(br_src))));

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(tos));

  p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (ent_vld == '0 && $stable(tos)));
endmodule

bind branch_hist_stack bh_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .br_valid (br_valid),
  .br_kind  (br_kind),
  .br_src   (br_src),
  .skip_cond(skip_cond),
  .skip_ret (skip_ret),
  .freeze   (freeze),
  .wipe     (wipe),
  .rd_idx   (rd_idx),
  .rd_vld   (rd_vld),
  .rd_src   (rd_src),
  .tos      (tos),
  .take     (take),
  .ent_vld  (ent_vld)
);

// File: tb/branch_hist_stack_tb_top.sv
`timescale 1ns/1ps
module branch_hist_stack_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int IDXW  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            br_valid;
  logic [2:0]      br_kind;
  logic [AW-1:0]   br_src, br_dst;
  logic            skip_cond, skip_ret, freeze, wipe;
  logic [IDXW-1:0] rd_idx;
  logic            rd_vld;
  logic [AW-1:0]   rd_src, rd_dst;
  logic [IDXW-1:0] tos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  branch_hist_stack #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
    .br_src(br_src), .br_dst(br_dst), .skip_cond(skip_cond), .skip_ret(skip_ret),
    .freeze(freeze), .wipe(wipe), .rd_idx(rd_idx), .rd_vld(rd_vld),
    .rd_src(rd_src), .rd_dst(rd_dst), .tos(tos)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  k;
    logic [31:0] src;
    logic        sc;
    logic        sr;
    logic [1:0]  etos;
    logic [31:0] esrc;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 3'd1, 32'h100, 1'b0, 1'b0, 2'd1, 32'h100},
    '{1'b1, 3'd0, 32'h110, 1'b0, 1'b0, 2'd2, 32'h110},
    '{1'b1, 3'd0, 32'h120, 1'b1, 1'b0, 2'd2, 32'h110},
    '{1'b1, 3'd3, 32'h130, 1'b0, 1'b1, 2'd2, 32'h110},
    '{1'b1, 3'd3, 32'h140, 1'b1, 1'b0, 2'd3, 32'h140},
    '{1'b1, 3'd0, 32'h150, 1'b0, 1'b1, 2'd0, 32'h150},
    '{1'b1, 3'd6, 32'h160, 1'b0, 1'b0, 2'd0, 32'h150},
    '{1'b0, 3'd2, 32'h170, 1'b0, 1'b0, 2'd0, 32'h150},
    '{1'b1, 3'd2, 32'h180, 1'b0, 1'b0, 2'd1, 32'h180},
    '{1'b1, 3'd4, 32'h190, 1'b0, 1'b0, 2'd2, 32'h190},
    '{1'b1, 3'd5, 32'h1A0, 1'b0, 1'b0, 2'd3, 32'h1A0},
    '{1'b1, 3'd7, 32'h1B0, 1'b0, 1'b0, 2'd3, 32'h1A0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [31:0] s);
    br_valid = v;
    br_kind  = k;
    br_src   = s;
    br_dst   = s + 32'h100;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 3'd0, '0);
    skip_cond = 0; skip_ret = 0; freeze = 0; wipe = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tos", 32'(tos), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = IDXW'(i);
      #1 chk("R1 vld", 32'(rd_vld), 0);
    end
    rd_idx = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // Table covers R2, R3, R4, R5 and the index-0 read of R6
    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i].v, TBL[i].k, TBL[i].src);
      skip_cond = TBL[i].sc;
      skip_ret  = TBL[i].sr;
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 row%0d tos", i), 32'(tos), 32'(TBL[i].etos));
      chk($sformatf("R6 row%0d src", i), rd_src, TBL[i].esrc);
      chk($sformatf("R6 row%0d dst", i), rd_dst, TBL[i].esrc + 32'h100);
    end
    drive(1'b0, 3'd0, '0);
    skip_cond = 0; skip_ret = 0;

    // R6: older entries, counted back from the newest
    rd_idx = 2'd1; #1 chk("R6 idx1", rd_src, 32'h190);
    rd_idx = 2'd2; #1 chk("R6 idx2", rd_src, 32'h180);
    rd_idx = 2'd3; #1 chk("R6 idx3", rd_src, 32'h150);
    chk("R6 idx3 vld", 32'(rd_vld), 1);

    // R9: capture and read of the overwritten slot in one cycle
    drive(1'b1, 3'd1, 32'h1C0);
    #1 chk("R9 old oldest", rd_src, 32'h150);
    @(negedge clk);
    drive(1'b0, 3'd0, '0);
    chk("R6 oldest replaced", rd_src, 32'h180);
    rd_idx = 2'd0; #1 chk("R2 newest after wrap", rd_src, 32'h1C0);
    chk("R2 tos wrap", 32'(tos), 0);

    // R7: freeze blocks capture and keeps contents
    freeze = 1'b1;
    drive(1'b1, 3'd2, 32'h1D0);
    @(negedge clk);
    chk("R7 tos", 32'(tos), 0);
    chk("R7 src", rd_src, 32'h1C0);
    freeze = 1'b0;

    // R8: wipe alongside a capture
    wipe = 1'b1;
    drive(1'b1, 3'd2, 32'h1E0);
    @(negedge clk);
    wipe = 1'b0;
    drive(1'b0, 3'd0, '0);
    chk("R8 tos kept", 32'(tos), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = IDXW'(i);
      #1 chk("R8 vld", 32'(rd_vld), 0);
      chk("R8 zero src", rd_src, 0);
    end
    rd_idx = '0;
    drive(1'b1, 3'd1, 32'h1F0);
    @(negedge clk);
    drive(1'b0, 3'd0, '0);
    chk("R8 post src", rd_src, 32'h1F0);
    chk("R2 post tos", 32'(tos), 1);
    rd_idx = 2'd1; #1 chk("R8 older still invalid", 32'(rd_vld), 0);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1 chk("R1 mid tos", 32'(tos), 0);
    rd_idx = 2'd0; #1 chk("R1 mid vld", 32'(rd_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule